// File: doc/BRIEF.md
# Packed Uniform Vector Write Port

This block takes single 32-bit register writes and assembles them into four-component vector constants, each component being a 24-bit float (1 sign bit, 7 exponent bits with bias 63, 16 mantissa bits). A setup register at offset 0 holds the index of the next constant and a format bit. Data register writes at offsets 1 to 8 are collected into a small word buffer. When the last word of a vector arrives, the block converts or unpacks the words and writes the whole vector into a 96-entry constant store in that same cycle. It then moves the index on to the next entry.

Two formats are supported. In the full-precision format four single-precision words make one vector. The exponent of each word is rebiased and its mantissa truncated to give the 24-bit float. In the packed format three words carry the four 24-bit values directly. A synchronous read port returns any stored vector, so the block's contents can be inspected.

Top module: `vec_const_port`

## Requirements
- R1: A write to offset 0 loads the index from data bits 6:0 and the format from bit 31 (1 = full-precision, 0 = packed). It also discards any partially collected words, so the next data write is word 0 of a new vector.
- R2: Data writes to any of offsets 1 to 8 are treated identically; the offset within that range has no effect.
- R3: In full-precision format the vector is stored in the clock edge of the 4th data write. The first word received becomes component w, the second z, the third y and the fourth x.
- R4: In packed format the vector is stored in the clock edge of the 3rd data write. With words a, b, c in arrival order: w = a[31:8], z = {a[7:0], b[31:16]}, y = {b[15:0], c[31:24]}, x = c[23:0].
- R5: After each stored vector the index visible on cur_idx increases by one and the word count restarts from zero.
- R6: A vector whose target index is above 95 is not stored, and the index does not advance. err is high for exactly the one cycle after the final word's clock edge.
- R7: The full-precision conversion works as follows. The exponent field e becomes e-64, the mantissa is bits 22:7 of the input word, and the sign is kept.
- R8: In the conversion, an input exponent of 64 or less gives a signed zero (exponent and mantissa 0). An input exponent of 191 or more, including infinities and NaNs, gives a signed infinity (exponent 127, mantissa 0).
- R9: rd_data shows the vector at rd_idx one clock after rd_idx is sampled. The packing is x in bits 23:0, y in 47:24, z in 71:48 and w in 95:72. An rd_idx above 95 reads as zero.
- R10: Writes to offsets 9 to 15 change neither the index, the format nor the word count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register offset (0 setup, 1 to 8 data) |
| wr_data | input | 32 | Register write data |
| rd_idx | input | 7 | Read index into constant store |
| rd_data | output | 96 | Stored vector {w,z,y,x} |
| cur_idx | output | 7 | Current target index |
| cur_fmt | output | 1 | Current format (1 = full-precision) |
| err | output | 1 | Out-of-range store pulse |

## Verification
The assertions rely on a few assumptions about the inputs. At most one register write happens per cycle. wr_addr and wr_data are known whenever wr_en is high. Software never starts a vector at an index it cannot name in 7 bits, so the index cannot wrap past 127. The stimulus keeps within these assumptions in the following ways. Every write is driven as a single-cycle strobe, with idle cycles between writes. Index sequences run only from 0 to 96. The out-of-range case is entered only by letting the index advance from 95.

// File: rtl/vec_const_port.sv
module vec_const_port #(
  parameter int DEPTH = 96,
  parameter int AW    = 4,
  parameter int IW    = 7,
  parameter int NDATA = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [95:0]   rd_data,
  output logic [IW-1:0] cur_idx,
  output logic          cur_fmt,
  output logic          err
);
  logic [IW-1:0] idx;
  logic          fmt;
  logic [1:0]    cnt;
  logic [31:0]   w0, w1, w2;
  logic [23:0]   cx, cy, cz, cw;
  logic [95:0]   mem [DEPTH];

  wire setup_wr = wr_en && (wr_addr == '0);
  wire data_wr  = wr_en && (wr_addr >= AW'(1)) && (wr_addr <= AW'(NDATA));
  wire last     = fmt ? (cnt == 2'd3) : (cnt == 2'd2);
  wire commit   = data_wr && last;
  wire in_range = 32'(idx) < DEPTH;

  function automatic logic [23:0] cvt(input logic [31:0] f);
    logic [7:0] e;
    e = f[30:23];
    if (e <= 8'd64)      cvt = {f[31], 23'd0};
    else if (e >= 8'd191) cvt = {f[31], 7'h7f, 16'd0};
    else                  cvt = {f[31], 7'(e - 8'd64), f[22:7]};
  endfunction

  always_comb begin
    if (fmt) begin
      cw = cvt(w0);
      cz = cvt(w1);
      cy = cvt(w2);
      cx = cvt(wr_data);
    end else begin
      cw = w0[31:8];
      cz = {w0[7:0], w1[31:16]};
      cy = {w1[15:0], wr_data[31:24]};
      cx = wr_data[23:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx <= '0;
      fmt <= 1'b0;
      cnt <= '0;
      w0  <= '0;
      w1  <= '0;
      w2  <= '0;
      err <= 1'b0;
    end else begin
      err <= commit && !in_range;
      if (setup_wr) begin
        idx <= wr_data[IW-1:0];
        fmt <= wr_data[31];
        cnt <= '0;
      end else if (data_wr) begin
        case (cnt)
          2'd0:    w0 <= wr_data;
          2'd1:    w1 <= wr_data;
          default: w2 <= wr_data;
        endcase
        if (commit) begin
          cnt <= '0;
          if (in_range) idx <= idx + IW'(1);
        end else begin
          cnt <= cnt + 2'd1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (commit && in_range) mem[idx] <= {cw, cz, cy, cx};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                   rd_data <= '0;
    else if (32'(rd_idx) < DEPTH) rd_data <= mem[rd_idx];
    else                          rd_data <= '0;
  end

  assign cur_idx = idx;
  assign cur_fmt = fmt;
endmodule

// File: rtl/vcp_checker.sv
module vcp_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [3:0]  wr_addr,
  input logic [31:0] wr_data,
  input logic [6:0]  idx,
  input logic        fmt,
  input logic [1:0]  cnt,
  input logic        commit,
  input logic        err
);
  p_setup_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 4'd0) |=> (cnt == 2'd0 && idx == $past(wr_data[6:0]) && fmt == $past(wr_data[31])));

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !fmt |-> cnt <= 2'd2);

  p_idx_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && idx < 7'd96) |=> (idx == $past(idx) + 7'd1 && cnt == 2'd0));

  p_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && idx > 7'd95) |=> (err && $stable(idx)));

  p_err_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);

  p_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr > 4'd8) |=> ($stable(idx) && $stable(cnt) && $stable(fmt)));
endmodule

bind vec_const_port vcp_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .idx(idx), .fmt(fmt), .cnt(cnt), .commit(commit), .err(err)
);

// File: tb/tb_vec_const_port.sv
`timescale 1ns/1ps
module tb_vec_const_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [6:0]  rd_idx = '0;
  logic [95:0] rd_data;
  logic [6:0]  cur_idx;
  logic        cur_fmt;
  logic        err;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vec_const_port dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .cur_idx(cur_idx), .cur_fmt(cur_fmt), .err(err)
  );

  task automatic chk(input string tag, input logic [95:0] got, input logic [95:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic setup(input int i, input bit f);
    wr(4'd0, {f, 24'd0, 7'(i)});
  endtask

  task automatic rd(input int i, output logic [95:0] v);
    @(negedge clk);
    rd_idx = 7'(i);
    @(negedge clk);
    v = rd_data;
  endtask

  function automatic logic [23:0] m_cvt(input logic [31:0] f);
    int e = int'(f[30:23]) - 64;
    if (e <= 0)   return {f[31], 23'd0};
    if (e >= 127) return {f[31], 7'd127, 16'd0};
    return {f[31], 7'(e), f[22:7]};
  endfunction

  function automatic logic [31:0] fw(input int i, input int k);
    return {1'((i ^ k) & 1), 8'((i * 7 + k * 53) % 256), 23'(i * 40503 + k * 977)};
  endfunction

  function automatic logic [31:0] pw(input int i, input int k);
    return 32'((i * 32'h9E3779B9) ^ (k * 32'h85EBCA6B)) + 32'(k);
  endfunction

  initial begin
    #(5 * 100000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [95:0] v, e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("reset idx", 96'(cur_idx), 96'd0);
    chk("reset fmt", 96'(cur_fmt), 96'd0);
    chk("reset err", 96'(err), 96'd0);
    chk("reset rd_data", rd_data, 96'd0);

    // R1 setup load
    setup(3, 1'b1);
    chk("R1 idx", 96'(cur_idx), 96'd3);
    chk("R1 fmt", 96'(cur_fmt), 96'd1);

    // R3 R2 R7 R8 R5: full-precision sweep over all indices and data offsets
    setup(0, 1'b1);
    for (int i = 0; i < 96; i++) begin
      for (int k = 0; k < 4; k++) wr(4'(1 + (i * 4 + k) % 8), fw(i, k));
      chk("R5 idx advance", 96'(cur_idx), 96'(i + 1));
      chk("R6 no err in range", 96'(err), 96'd0);
    end
    for (int i = 0; i < 96; i++) begin
      rd(i, v);
      e = {m_cvt(fw(i, 0)), m_cvt(fw(i, 1)), m_cvt(fw(i, 2)), m_cvt(fw(i, 3))};
      chk("R3 R7 R2 full vector", v, e);
    end

    // R4 packed sweep
    setup(0, 1'b0);
    for (int i = 0; i < 96; i++) begin
      for (int k = 0; k < 3; k++) wr(4'(8 - (i + k) % 8), pw(i, k));
      chk("R4 R5 idx advance", 96'(cur_idx), 96'(i + 1));
    end
    for (int i = 0; i < 96; i++) begin
      logic [31:0] a, b, c;
      a = pw(i, 0); b = pw(i, 1); c = pw(i, 2);
      rd(i, v);
      e = {a[31:8], a[7:0], b[31:16], b[15:0], c[31:24], c[23:0]};
      chk("R4 packed vector", v, e);
    end

    // R8 corners
    setup(10, 1'b1);
    wr(4'd1, 32'h00000000); wr(4'd2, 32'hA0123456); wr(4'd3, 32'hDF800000); wr(4'd4, 32'h3F800000);
    setup(11, 1'b1);
    wr(4'd5, 32'h5F000000); wr(4'd6, 32'h20800080); wr(4'd7, 32'h7F800000); wr(4'd8, 32'hFFC00000);
    rd(10, v);
    chk("R8 flush and saturate", v, {24'h000000, 24'h800000, 24'hFF0000, 24'h3F0000});
    rd(11, v);
    chk("R7 R8 edges", v, {24'h7E0000, 24'h010001, 24'h7F0000, 24'hFF0000});

    // R6 drop above 95
    setup(95, 1'b0);
    wr(4'd1, 32'h11111111); wr(4'd1, 32'h22222222); wr(4'd1, 32'h33333333);
    chk("R6 idx to 96", 96'(cur_idx), 96'd96);
    chk("R6 no err at 95", 96'(err), 96'd0);
    wr(4'd1, 32'hAAAAAAAA); wr(4'd1, 32'hBBBBBBBB);
    chk("R6 no early err", 96'(err), 96'd0);
    wr(4'd1, 32'hCCCCCCCC);
    chk("R6 err pulse", 96'(err), 96'd1);
    chk("R6 idx held", 96'(cur_idx), 96'd96);
    @(negedge clk);
    chk("R6 err one cycle", 96'(err), 96'd0);
    rd(95, v);
    chk("R6 entry 95 intact", v, {24'h111111, 24'h112222, 24'h222233, 24'h333333});

    // R10 unmapped offsets ignored
    setup(5, 1'b1);
    wr(4'd1, 32'h3F800000); wr(4'd2, 32'h40000000);
    wr(4'd9, 32'h12345678); wr(4'd15, 32'h87654321);
    chk("R10 idx unchanged", 96'(cur_idx), 96'd5);
    chk("R10 fmt unchanged", 96'(cur_fmt), 96'd1);
    wr(4'd3, 32'h40400000);
    chk("R10 count not advanced", 96'(cur_idx), 96'd5);
    wr(4'd4, 32'hBF800000);
    chk("R10 commit on 4th", 96'(cur_idx), 96'd6);
    rd(5, v);
    chk("R10 vector", v, {m_cvt(32'h3F800000), m_cvt(32'h40000000), m_cvt(32'h40400000), m_cvt(32'hBF800000)});

    // R1 setup clears partial words
    setup(7, 1'b1);
    wr(4'd1, 32'hDEADBEEF); wr(4'd1, 32'hCAFEF00D);
    setup(7, 1'b1);
    for (int k = 0; k < 4; k++) wr(4'd2, fw(50, k));
    chk("R1 clear idx", 96'(cur_idx), 96'd8);
    rd(7, v);
    chk("R1 clear vector", v, {m_cvt(fw(50, 0)), m_cvt(fw(50, 1)), m_cvt(fw(50, 2)), m_cvt(fw(50, 3))});

    // R9 out-of-range read
    rd(100, v);
    chk("R9 out of range read", v, 96'd0);
    rd(127, v);
    chk("R9 top read", v, 96'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule